// File: doc/BRIEF.md
# Three-Port Shared Packet Memory Arbiter

This block decides, cycle by cycle, which of three requesters may touch a single-port byte-wide packet memory: a processor port, a transmit DMA engine that reads packet bytes out of memory, and a receive DMA engine that writes packet bytes into memory. Each DMA also reports how full its own FIFO is. The arbiter turns that fill level into a high or low urgency, so that a transmit FIFO about to run dry, or a receive FIFO about to overflow, is served ahead of the processor.

Processor writes are captured in a one-entry holding register and complete at once, with no stall. The stored byte is written to memory later, when the processor side wins arbitration. Processor reads hold the processor on a wait line until the memory has returned the byte. A DMA grant is a one-cycle pulse that carries one byte. Two DMA grants are never issued in consecutive cycles, so each DMA port moves at most one byte every two clocks. The memory is a synchronous RAM: read data appears the cycle after the enable.

Top module: `shmem_arbiter`

## Requirements
- R1: The receive DMA is urgent when its fill level is strictly greater than FIFO_DEPTH/2. The transmit DMA is urgent when its fill level is strictly less than FIFO_DEPTH/2. Any other level is non-urgent.
- R2: Among eligible requests, the order of service is urgent receive, urgent transmit, processor, non-urgent receive, non-urgent transmit.
- R3: When both DMAs are eligible at the same urgency, the one that did not get the most recent DMA grant wins. After reset, receive wins the first such tie.
- R4: No DMA grant (rxGnt or txGnt) is issued in the cycle after a DMA grant.
- R5: At most one of rxGnt, txGnt, cpuGnt is high in a cycle. In that same cycle memEn is high, memAddr carries the winner's address, and memWe is high only for a receive or processor write grant, with memWdata set to the byte being written.
- R6: A processor write (cpuReq=1, cpuWe=1) that finds the holding register empty sees cpuWait=0 and completes in that cycle. The byte is written to memory at a later cpuGnt, with the captured address and data.
- R7: A processor access that arrives while the holding register is full sees cpuWait=1 until the cycle after the held byte's cpuGnt.
- R8: A processor read sees cpuWait=1 up to and including the cycle of its cpuGnt. In the next cycle it sees cpuWait=0, and rdData holds the byte at cpuAddr.
- R9: When no request is present, no grant is issued, memEn is 0 and cpuWait is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held while cpuWait is high |
| cpuWe | input | 1 | Processor access is a write |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuWdata | input | 8 | Processor write byte |
| cpuWait | output | 1 | Processor must hold its access another cycle |
| cpuGnt | output | 1 | Memory slot given to the processor side this cycle |
| rxReq | input | 1 | Receive DMA wants to write one byte |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxAddr | input | ADDR_W | Receive DMA byte address |
| rxWdata | input | 8 | Receive DMA byte to store |
| rxGnt | output | 1 | One-cycle receive grant |
| txReq | input | 1 | Transmit DMA wants to read one byte |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| txAddr | input | ADDR_W | Transmit DMA byte address |
| txGnt | output | 1 | One-cycle transmit grant |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, one cycle after memEn |
| rdData | output | 8 | Read byte for the processor or transmit DMA |

## Verification
The bench probes fill levels exactly at the half mark. A design that compares with the wrong inequality would show the wrong DMA ahead of the processor there. Equal-urgency DMA pairs are repeated, because a fixed tie-break would grant the same engine twice in a row. Both DMAs are also held high across several cycles, where an arbiter that ignores the spacing rule hands out a DMA grant on consecutive clocks. Processor writes are stacked behind a full holding register, and reads are issued against a competing urgent DMA. A design that drops the stall or releases it one cycle early would lose the second write or return stale read data.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;

  // Strobes from the arbitration control to the datapath, one cycle wide.
  typedef struct packed {
    logic selRx;     // receive DMA owns the memory slot
    logic selTx;     // transmit DMA owns the memory slot
    logic selCpuRd;  // processor read owns the memory slot
    logic selCpuWr;  // held processor write drains into memory
    logic loadWb;    // capture a new processor write in the holding register
  } arb_strobe_t;

  typedef enum logic [2:0] {
    PICK_NONE,
    PICK_RX,
    PICK_TX,
    PICK_CPU
  } pick_e;

endpackage

// File: rtl/shmem_arb_prio.sv
module shmem_arb_prio #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter bit HIGH_ABOVE = 1'b1
) (
  input  logic [LVL_W-1:0] level,
  output logic             isHigh
);

  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

  generate
    if (HIGH_ABOVE) begin : g_fill_urgent
      // receive side: urgent when nearly full
      assign isHigh = level > HALF_LVL;
    end else begin : g_drain_urgent
      // transmit side: urgent when nearly empty
      assign isHigh = level < HALF_LVL;
    end
  endgenerate

endmodule

// File: rtl/shmem_arb_ctrl.sv
module shmem_arb_ctrl
  import shmem_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        rxReq,
  input  logic        rxHi,
  input  logic        txReq,
  input  logic        txHi,
  output arb_strobe_t strb,
  output logic        cpuWait,
  output logic        cpuGnt,
  output logic        rxGnt,
  output logic        txGnt
);

  logic  wbValid;    // holding register has an unwritten byte
  logic  rdPending;  // processor read was granted last cycle
  logic  lastDma;    // a DMA grant was issued last cycle
  logic  rrRxNext;   // receive wins the next equal-urgency tie
  logic  rxElig, txElig, cpuArb;
  pick_e pick;

  assign rxElig = rxReq && !lastDma;
  assign txElig = txReq && !lastDma;
  assign cpuArb = wbValid || (cpuReq && !cpuWe && !rdPending);

  always_comb begin
    pick = PICK_NONE;
    if (rxElig && rxHi && txElig && txHi)
      pick = rrRxNext ? PICK_RX : PICK_TX;
    else if (rxElig && rxHi)
      pick = PICK_RX;
    else if (txElig && txHi)
      pick = PICK_TX;
    else if (cpuArb)
      pick = PICK_CPU;
    else if (rxElig && txElig)
      pick = rrRxNext ? PICK_RX : PICK_TX;
    else if (rxElig)
      pick = PICK_RX;
    else if (txElig)
      pick = PICK_TX;
  end

  always_comb begin
    strb.selRx    = (pick == PICK_RX);
    strb.selTx    = (pick == PICK_TX);
    strb.selCpuWr = (pick == PICK_CPU) && wbValid;
    strb.selCpuRd = (pick == PICK_CPU) && !wbValid;
    strb.loadWb   = cpuReq && cpuWe && !wbValid;
  end

  assign rxGnt   = strb.selRx;
  assign txGnt   = strb.selTx;
  assign cpuGnt  = strb.selCpuWr || strb.selCpuRd;
  assign cpuWait = cpuReq && (cpuWe ? wbValid : !rdPending);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid   <= 1'b0;
      rdPending <= 1'b0;
      lastDma   <= 1'b0;
      rrRxNext  <= 1'b1;
    end else begin
      if (strb.loadWb)
        wbValid <= 1'b1;
      else if (strb.selCpuWr)
        wbValid <= 1'b0;
      rdPending <= strb.selCpuRd;
      lastDma   <= strb.selRx || strb.selTx;
      if (strb.selRx || strb.selTx)
        rrRxNext <= strb.selTx;
    end
  end

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxGnt, txGnt, cpuGnt}));

  // R4
  dma_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxGnt || txGnt) |=> !(rxGnt || txGnt));

  // R2
  rx_hi_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && rxHi && !(txReq && txHi) && !lastDma) |-> rxGnt);

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && wbValid) |-> cpuWait);

  // R8
  read_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && !cpuWait) |-> $past(cpuGnt));

endmodule

// File: rtl/shmem_arb_dp.sv
module shmem_arb_dp
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  arb_strobe_t       strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic [7:0]        rxWdata,
  input  logic [ADDR_W-1:0] txAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic [7:0]        rdData
);

  logic [ADDR_W-1:0] wbAddr;
  logic [7:0]        wbData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAddr <= '0;
      wbData <= '0;
    end else if (strb.loadWb) begin
      wbAddr <= cpuAddr;
      wbData <= cpuWdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = wbData;
    if (strb.selRx) begin
      memAddr  = rxAddr;
      memWdata = rxWdata;
    end else if (strb.selTx) begin
      memAddr = txAddr;
    end else if (strb.selCpuWr) begin
      memAddr = wbAddr;
    end else if (strb.selCpuRd) begin
      memAddr = cpuAddr;
    end
  end

  assign memEn  = strb.selRx || strb.selTx || strb.selCpuWr || strb.selCpuRd;
  assign memWe  = strb.selRx || strb.selCpuWr;
  assign rdData = memRdata;

  // R6
  drain_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selCpuWr && !$past(strb.loadWb)) |-> $stable(wbData));

  // R5
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic              cpuWait,
  output logic              cpuGnt,
  input  logic              rxReq,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic [7:0]        rxWdata,
  output logic              rxGnt,
  input  logic              txReq,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [ADDR_W-1:0] txAddr,
  output logic              txGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic [7:0]        rdData
);

  arb_strobe_t strb;
  logic        rxHi, txHi;

  shmem_arb_prio #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .HIGH_ABOVE(1'b1))
    u_rxPrio (.level(rxLevel), .isHigh(rxHi));

  shmem_arb_prio #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .HIGH_ABOVE(1'b0))
    u_txPrio (.level(txLevel), .isHigh(txHi));

  shmem_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe),
    .rxReq(rxReq), .rxHi(rxHi),
    .txReq(txReq), .txHi(txHi),
    .strb(strb), .cpuWait(cpuWait), .cpuGnt(cpuGnt),
    .rxGnt(rxGnt), .txGnt(txGnt)
  );

  shmem_arb_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .rxAddr(rxAddr), .rxWdata(rxWdata), .txAddr(txAddr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .rdData(rdData)
  );

endmodule

// File: tb/shmem_arbiter_test.sv
module shmem_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int LW = 5;
  localparam int NVEC = 15;

  // vector: rxReq, rxLevel, txReq, txLevel, cpu read, expected winner (0 none,1 rx,2 tx,3 cpu)
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {1'b1, 5'd3,  1'b0, 5'd0,  1'b0, 2'd1},  // R2 non-urgent rx alone
    {1'b0, 5'd0,  1'b1, 5'd12, 1'b0, 2'd2},  // R2 non-urgent tx alone
    {1'b1, 5'd9,  1'b0, 5'd0,  1'b1, 2'd1},  // R1 rx 9 urgent beats cpu
    {1'b1, 5'd8,  1'b0, 5'd0,  1'b1, 2'd3},  // R1 rx 8 not urgent
    {1'b0, 5'd0,  1'b1, 5'd7,  1'b1, 2'd2},  // R1 tx 7 urgent beats cpu
    {1'b0, 5'd0,  1'b1, 5'd8,  1'b1, 2'd3},  // R1 tx 8 not urgent
    {1'b1, 5'd9,  1'b1, 5'd0,  1'b0, 2'd1},  // R3 urgent tie, rx turn
    {1'b1, 5'd9,  1'b1, 5'd0,  1'b0, 2'd2},  // R3 urgent tie, tx turn
    {1'b1, 5'd2,  1'b1, 5'd15, 1'b0, 2'd1},  // R3 low tie, rx turn
    {1'b1, 5'd2,  1'b1, 5'd15, 1'b0, 2'd2},  // R3 low tie, tx turn
    {1'b1, 5'd0,  1'b1, 5'd3,  1'b0, 2'd2},  // R2 urgent tx over low rx
    {1'b1, 5'd16, 1'b1, 5'd0,  1'b1, 2'd1},  // R2 urgent rx over all
    {1'b1, 5'd1,  1'b1, 5'd10, 1'b1, 2'd3},  // R2 cpu over low dmas
    {1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0},  // R9 idle
    {1'b1, 5'd5,  1'b1, 5'd4,  1'b1, 2'd2}   // R2 urgent tx over cpu
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [7:0]    cpuWdata = '0;
  logic          cpuWait, cpuGnt;
  logic          rxReq = 1'b0;
  logic [LW-1:0] rxLevel = '0;
  logic [AW-1:0] rxAddr = '0;
  logic [7:0]    rxWdata = '0;
  logic          rxGnt;
  logic          txReq = 1'b0;
  logic [LW-1:0] txLevel = '0;
  logic [AW-1:0] txAddr = '0;
  logic          txGnt;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata, memRdata, rdData;

  logic [7:0] ram [0:(1<<AW)-1];
  logic [7:0] ramQ = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int a = 0; a < (1 << AW); a++) ram[a] = 8'(a) ^ 8'h3C;
  end

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr] <= memWdata;
      else ramQ <= ram[memAddr];
    end
  end
  assign memRdata = ramQ;

  shmem_arbiter uut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuWait(cpuWait), .cpuGnt(cpuGnt),
    .rxReq(rxReq), .rxLevel(rxLevel), .rxAddr(rxAddr), .rxWdata(rxWdata), .rxGnt(rxGnt),
    .txReq(txReq), .txLevel(txLevel), .txAddr(txAddr), .txGnt(txGnt),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample just after
  task automatic setIn(input logic cr, input logic cw, input logic [AW-1:0] ca,
                       input logic [7:0] cd, input logic rr, input logic [LW-1:0] rl,
                       input logic tr, input logic [LW-1:0] tl);
    @(negedge clk);
    cpuReq = cr; cpuWe = cw; cpuAddr = ca; cpuWdata = cd;
    rxReq = rr; rxLevel = rl; txReq = tr; txLevel = tl;
    #1;
  endtask

  task automatic idle();
    setIn(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 grants", {29'd0, rxGnt, txGnt, cpuGnt}, 32'd0);
    check("R9 memEn", memEn, 1'b0);
    check("R9 cpuWait", cpuWait, 1'b0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      rxAddr = AW'(12'h100 + i); rxWdata = 8'(8'h80 + i); txAddr = AW'(12'h200 + i);
      setIn(VEC[i][2], 1'b0, 12'h010, '0, VEC[i][14], VEC[i][13:9], VEC[i][8], VEC[i][7:3]);
      check("R2 winner", {29'd0, rxGnt, txGnt, cpuGnt},
            (VEC[i][1:0] == 2'd1) ? 32'd4 : (VEC[i][1:0] == 2'd2) ? 32'd2 :
            (VEC[i][1:0] == 2'd3) ? 32'd1 : 32'd0);
      check("R5 memEn", memEn, VEC[i][1:0] != 2'd0);
      check("R5 memWe", memWe, VEC[i][1:0] == 2'd1);
      if (VEC[i][1:0] != 2'd0)
        check("R5 memAddr", memAddr, (VEC[i][1:0] == 2'd1) ? rxAddr :
                                     (VEC[i][1:0] == 2'd2) ? txAddr : 12'h010);
      idle();
    end

    // R4 both urgent DMAs held for three cycles
    rxAddr = 12'h1F0; txAddr = 12'h2F0;
    setIn(1'b0, 1'b0, '0, '0, 1'b1, 5'd12, 1'b1, 5'd1);
    check("R4 first rx", {30'd0, rxGnt, txGnt}, 32'd2);
    setIn(1'b0, 1'b0, '0, '0, 1'b1, 5'd12, 1'b1, 5'd1);
    check("R4 spacing", {30'd0, rxGnt, txGnt}, 32'd0);
    setIn(1'b0, 1'b0, '0, '0, 1'b1, 5'd12, 1'b1, 5'd1);
    check("R4 then tx", {30'd0, rxGnt, txGnt}, 32'd1);
    idle();

    // R6 posted write then R8 uncontended read
    setIn(1'b1, 1'b1, 12'h055, 8'hA5, 1'b0, '0, 1'b0, '0);
    check("R6 no wait", cpuWait, 1'b0);
    idle();
    check("R6 drain gnt", cpuGnt, 1'b1);
    check("R6 drain we", memWe, 1'b1);
    check("R6 drain addr", memAddr, 12'h055);
    check("R6 drain data", memWdata, 8'hA5);
    setIn(1'b1, 1'b0, 12'h055, '0, 1'b0, '0, 1'b0, '0);
    check("R8 wait at gnt", {30'd0, cpuWait, cpuGnt}, 32'd3);
    setIn(1'b1, 1'b0, 12'h055, '0, 1'b0, '0, 1'b0, '0);
    check("R8 released", cpuWait, 1'b0);
    check("R8 data", rdData, 8'hA5);
    idle();

    // R7 second write behind a full holding register
    rxAddr = 12'h1E0; rxWdata = 8'h11;
    setIn(1'b1, 1'b1, 12'h066, 8'h5A, 1'b1, 5'd14, 1'b0, '0);
    check("R7 first write", {30'd0, cpuWait, rxGnt}, 32'd1);
    setIn(1'b1, 1'b1, 12'h077, 8'hC3, 1'b1, 5'd14, 1'b0, '0);
    check("R7 stall", cpuWait, 1'b1);
    check("R7 drain first", {31'd0, cpuGnt}, 32'd1);
    check("R7 drain addr", memAddr, 12'h066);
    setIn(1'b1, 1'b1, 12'h077, 8'hC3, 1'b1, 5'd14, 1'b0, '0);
    check("R7 accepted", {30'd0, cpuWait, rxGnt}, 32'd1);
    setIn(1'b0, 1'b0, '0, '0, 1'b1, 5'd14, 1'b0, '0);
    check("R7 drain second", {31'd0, cpuGnt}, 32'd1);
    check("R7 second data", {20'd0, memAddr, memWdata}, {20'd0, 12'h077, 8'hC3});
    idle();

    // R8 read against an urgent receive DMA
    setIn(1'b1, 1'b0, 12'h300, '0, 1'b1, 5'd15, 1'b0, '0);
    check("R8 lost to rx", {29'd0, cpuWait, rxGnt, cpuGnt}, 32'd6);
    setIn(1'b1, 1'b0, 12'h300, '0, 1'b1, 5'd15, 1'b0, '0);
    check("R8 late gnt", {30'd0, cpuWait, cpuGnt}, 32'd3);
    setIn(1'b1, 1'b0, 12'h300, '0, 1'b0, '0, 1'b0, '0);
    check("R8 late release", cpuWait, 1'b0);
    check("R8 late data", rdData, 8'h3C);
    idle();

    // R6 second posted byte really reached memory
    setIn(1'b1, 1'b0, 12'h077, '0, 1'b0, '0, 1'b0, '0);
    setIn(1'b1, 1'b0, 12'h077, '0, 1'b0, '0, 1'b0, '0);
    check("R6 readback", rdData, 8'hC3);
    idle();
    check("R9 idle", {30'd0, memEn, cpuWait}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule